// File: doc/BRIEF.md
# Transmit Start Poll Scheduler

This block decides when a MAC transmitter begins a frame. Once the transmitter is enabled, a free-running poll timer produces a check of the head transmit descriptor's ready flag once per poll period. The default period is 256 clocks. Software can raise a one-cycle transmit-now strobe, which forces a check without waiting for the timer. If that strobe arrives while a frame is on the wire, the block keeps it in a latch and acts on it at the next gap between frames.

Full-duplex links can also have a flow-control frame waiting in a dedicated slot. The block looks at that slot in every cycle between frames, but only when flow control is on and the slot reports a complete frame. When it grants a start, the block emits a single-cycle start pulse together with a source bit that says which source the data path should fetch from. It then holds a busy flag until the data path reports end of frame. Descriptor fetch, DMA and serialization are outside this block.

The controller has four states:

- **OFF**: disabled and idle.
- **IDLE**: enabled, between frames.
- **LAUNCH**: the one cycle in which the start pulse is driven.
- **BUSY**: a frame is in progress.

The transitions are:

- **enable** takes OFF to IDLE.
- **disable** takes IDLE to OFF.
- **grant** takes IDLE to LAUNCH.
- **commit** takes LAUNCH to BUSY.
- **finish** takes BUSY back to IDLE when the block is still enabled, or to OFF when it is not.

Top module: `txstart_sched`

## Requirements
- R1: While `tx_enable` is low and no frame is in progress, no start pulse is produced, whatever the ready flags and strobe do.
- R2: After `tx_enable` rises, the poll timer starts at zero. With the head ready, the first start pulse appears exactly POLL_PERIOD (256) cycles after the first enabled clock edge, and never earlier.
- R3: After reset, `start_pulse` and `busy` are 0. A start pulse is exactly one cycle wide. `busy` rises with it and stays high until the clock edge that samples `frame_done` high, and is low from the following cycle.
- R4: A `tod_strobe` seen between frames with the head ready gives a start pulse in the next cycle, with `start_src` = 0 (normal queue).
- R5: A `tod_strobe` seen during a frame is latched. Provided the block is enabled, the latched request causes a head check on the first clock edge after the block returns to IDLE, so the start pulse follows two cycles after the edge that samples `frame_done`.
- R6: A check (tick or strobe) that finds the head not ready is used up. Making the head ready afterwards starts nothing until the next poll tick.
- R7: Between frames, when `full_duplex`, `fc_enable` and `fc_slot_full` are all high, a start pulse follows in the next cycle with `start_src` = 1 (flow-control slot).
- R8: A full flow-control slot starts nothing when `fc_enable` is low or `full_duplex` is low.
- R9: When the flow-control slot and a normal check are ready in the same cycle, the flow-control frame starts first. The normal check is kept and served at the next gap between frames.
- R10: Lowering `tx_enable` lets the current frame finish, with `busy` held until `frame_done`. After that, no start occurs, and strobes seen while disabled are dropped. Re-enabling restarts the poll timer from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmitter enable |
| full_duplex | input | 1 | Link runs full duplex |
| fc_enable | input | 1 | Flow-control frames allowed |
| fc_slot_full | input | 1 | Flow-control slot holds a complete frame |
| head_ready | input | 1 | Ready flag of the head transmit descriptor |
| tod_strobe | input | 1 | One-cycle transmit-now request from software |
| frame_done | input | 1 | End of the frame in progress |
| start_pulse | output | 1 | One-cycle frame start grant |
| start_src | output | 1 | Source of the granted frame: 0 normal queue, 1 flow-control slot |
| busy | output | 1 | Frame in progress |

## Verification
The main function is tried with four kinds of stimulus:

- **Timer only.** The head is ready and only the poll timer runs. The exact cycle of the start separates a correct 256-cycle period from an off-by-one count, and the re-enable case shows whether the timer restarts from zero.
- **Strobe patterns.** A strobe between frames tests the immediate path. A strobe during a frame tests the latch. A strobe against a head that is not ready tests whether the check is used up.
- **Flow-control gating.** The flow-control slot is filled under each setting of the enable and duplex gates, which exposes a missing gate term.
- **Simultaneous sources.** Both sources are made ready at once. This separates the correct priority from a swapped one, and also shows whether the losing normal request survives the flow-control frame.

// File: rtl/txs_pkg.sv
package txs_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_BUSY   = 2'd3
    } txs_state_e;

    typedef enum logic {
        SRC_QUEUE   = 1'b0,
        SRC_FLOWCTL = 1'b1
    } txs_src_e;

endpackage

// File: rtl/txs_poll_timer.sv
module txs_poll_timer #(
    parameter int POLL_PERIOD = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (POLL_PERIOD > 2) ? $clog2(POLL_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(POLL_PERIOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/txs_demand_latch.sv
module txs_demand_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic strobe_i,
    input  logic tick_i,
    input  logic consume_i,
    output logic pend_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            pend_q <= 1'b0;
        end else if (consume_i) begin
            pend_q <= 1'b0;
        end else if (strobe_i || tick_i) begin
            pend_q <= 1'b1;
        end
    end

    assign pend_o = pend_q;

    // R6
    consume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i |=> !pend_o);

    // R10
    off_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pend_o);

endmodule

// File: rtl/txs_start_fsm.sv
module txs_start_fsm
    import txs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fc_ok_i,
    input  logic check_i,
    input  logic head_ready_i,
    input  logic done_i,
    output logic consume_o,
    output logic start_o,
    output logic src_o,
    output logic busy_o
);
    txs_state_e state_q, state_d;
    txs_src_e   src_q, src_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            src_q   <= SRC_QUEUE;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        src_d     = src_q;
        consume_o = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (en_i) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!en_i) begin
                    state_d = ST_OFF;
                end else if (fc_ok_i) begin
                    state_d = ST_LAUNCH;
                    src_d   = SRC_FLOWCTL;
                end else if (check_i) begin
                    consume_o = 1'b1;
                    if (head_ready_i) begin
                        state_d = ST_LAUNCH;
                        src_d   = SRC_QUEUE;
                    end
                end
            end
            ST_LAUNCH: begin
                state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (done_i) state_d = en_i ? ST_IDLE : ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        start_o = (state_q == ST_LAUNCH);
        busy_o  = (state_q == ST_LAUNCH) || (state_q == ST_BUSY);
        src_o   = src_q;
    end

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (!start_o && busy_o));

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_i) |=> busy_o);

    // R1
    start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(en_i));

    // R7
    fc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && src_o) |-> $past(fc_ok_i));

    // R9
    fc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !src_o) |-> !$past(fc_ok_i));

endmodule

// File: rtl/txstart_sched.sv
module txstart_sched #(
    parameter int POLL_PERIOD = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_enable,
    input  logic full_duplex,
    input  logic fc_enable,
    input  logic fc_slot_full,
    input  logic head_ready,
    input  logic tod_strobe,
    input  logic frame_done,
    output logic start_pulse,
    output logic start_src,
    output logic busy
);
    logic tick;
    logic pend;
    logic consume;
    logic fc_ok;
    logic check;

    assign fc_ok = full_duplex && fc_enable && fc_slot_full;
    assign check = pend || tod_strobe || tick;

    txs_poll_timer #(.POLL_PERIOD(POLL_PERIOD)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tx_enable),
        .tick_o (tick)
    );

    txs_demand_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (tx_enable),
        .strobe_i  (tod_strobe),
        .tick_i    (tick),
        .consume_i (consume),
        .pend_o    (pend)
    );

    txs_start_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (tx_enable),
        .fc_ok_i      (fc_ok),
        .check_i      (check),
        .head_ready_i (head_ready),
        .done_i       (frame_done),
        .consume_o    (consume),
        .start_o      (start_pulse),
        .src_o        (start_src),
        .busy_o       (busy)
    );

    // R8
    fc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && start_src) |-> $past(fc_enable && full_duplex));

endmodule

// File: tb/txstart_sched_tb.sv
module txstart_sched_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_enable = 1'b0, full_duplex = 1'b0, fc_enable = 1'b0, fc_slot_full = 1'b0;
    logic head_ready = 1'b0, tod_strobe = 1'b0, frame_done = 1'b0;
    logic start_pulse, start_src, busy;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int tbase = 0;

    int    exp_cyc[$];
    bit    exp_src[$];
    string exp_tag[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    txstart_sched #(.POLL_PERIOD(256)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .full_duplex(full_duplex),
        .fc_enable(fc_enable), .fc_slot_full(fc_slot_full), .head_ready(head_ready),
        .tod_strobe(tod_strobe), .frame_done(frame_done),
        .start_pulse(start_pulse), .start_src(start_src), .busy(busy)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_start(bit src, int at, string tag);
        exp_src.push_back(src);
        exp_cyc.push_back(at);
        exp_tag.push_back(tag);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic end_frame();
        step(2);
        frame_done = 1'b1;
        step(1);
        frame_done = 1'b0;
        step(1);
    endtask

    // monitor: pops the scoreboard on every start pulse
    always @(negedge clk) begin
        if (rst_n && start_pulse) begin
            if (exp_cyc.size() == 0) begin
                chk("R1 unexpected start", 1, 0);
            end else begin
                automatic int    ec = exp_cyc.pop_front();
                automatic bit    es = exp_src.pop_front();
                automatic string et = exp_tag.pop_front();
                chk({et, " start cycle"}, cyc, ec);
                chk({et, " start source"}, int'(start_src), int'(es));
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        int c;
        int nt;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R3 reset state
        chk("R3 reset busy", int'(busy), 0);
        chk("R3 reset start", int'(start_pulse), 0);

        // R1: disabled, ready + strobe give nothing
        head_ready = 1'b1;
        tod_strobe = 1'b1;
        step(1);
        tod_strobe = 1'b0;
        step(5);
        chk("R1 busy while off", int'(busy), 0);

        // R2: first poll after enable
        c = cyc;
        tx_enable = 1'b1;
        tbase = c + 256;
        expect_start(1'b0, c + 256, "R2");
        step(255);
        chk("R2 not early", int'(busy), 0);
        step(1);
        chk("R2 busy at start", int'(busy), 1);
        head_ready = 1'b0;

        // R3: one-cycle pulse and busy hold
        step(1);
        chk("R3 pulse width", int'(start_pulse), 0);
        chk("R3 busy held", int'(busy), 1);
        step(10);
        chk("R3 busy held long", int'(busy), 1);
        frame_done = 1'b1;
        step(1);
        frame_done = 1'b0;
        chk("R3 busy cleared", int'(busy), 0);

        // R4: immediate strobe
        step(2);
        c = cyc;
        head_ready = 1'b1;
        tod_strobe = 1'b1;
        expect_start(1'b0, c + 1, "R4");
        step(1);
        tod_strobe = 1'b0;
        head_ready = 1'b0;

        // R5: strobe during a frame is latched
        step(1);
        tod_strobe = 1'b1;
        step(1);
        tod_strobe = 1'b0;
        step(5);
        head_ready = 1'b1;
        c = cyc;
        frame_done = 1'b1;
        expect_start(1'b0, c + 2, "R5");
        step(1);
        frame_done = 1'b0;
        step(1);
        head_ready = 1'b0;
        end_frame();

        // R6: check against an unready head is used up
        tod_strobe = 1'b1;
        step(1);
        tod_strobe = 1'b0;
        step(3);
        head_ready = 1'b1;
        step(4);
        chk("R6 no start before tick", int'(busy), 0);
        nt = tbase;
        while (nt <= cyc) nt += 256;
        expect_start(1'b0, nt, "R6");
        while (cyc < nt) step(1);
        head_ready = 1'b0;
        end_frame();

        // R7: flow-control slot
        full_duplex = 1'b1;
        fc_enable = 1'b1;
        c = cyc;
        fc_slot_full = 1'b1;
        expect_start(1'b1, c + 1, "R7");
        step(1);
        fc_slot_full = 1'b0;
        end_frame();

        // R8: gating of the slot
        fc_enable = 1'b0;
        fc_slot_full = 1'b1;
        step(20);
        chk("R8 fc disabled", int'(busy), 0);
        fc_enable = 1'b1;
        full_duplex = 1'b0;
        step(20);
        chk("R8 half duplex", int'(busy), 0);
        fc_slot_full = 1'b0;
        full_duplex = 1'b1;
        step(2);

        // R9: flow control first, normal kept
        c = cyc;
        fc_slot_full = 1'b1;
        head_ready = 1'b1;
        tod_strobe = 1'b1;
        expect_start(1'b1, c + 1, "R9");
        step(1);
        tod_strobe = 1'b0;
        fc_slot_full = 1'b0;
        step(3);
        c = cyc;
        frame_done = 1'b1;
        expect_start(1'b0, c + 2, "R9");
        step(1);
        frame_done = 1'b0;
        step(1);
        head_ready = 1'b0;
        end_frame();

        // R10: disable mid-frame
        step(2);
        c = cyc;
        tod_strobe = 1'b1;
        head_ready = 1'b1;
        expect_start(1'b0, c + 1, "R10");
        step(1);
        tod_strobe = 1'b0;
        tx_enable = 1'b0;
        step(5);
        chk("R10 frame finishes", int'(busy), 1);
        tod_strobe = 1'b1;
        step(1);
        tod_strobe = 1'b0;
        frame_done = 1'b1;
        step(1);
        frame_done = 1'b0;
        step(1);
        chk("R10 idle after finish", int'(busy), 0);
        step(300);
        chk("R10 no start while off", int'(busy), 0);
        c = cyc;
        tx_enable = 1'b1;
        expect_start(1'b0, c + 256, "R10");
        step(255);
        chk("R10 timer restarted", int'(busy), 0);
        step(1);
        head_ready = 1'b0;
        end_frame();

        step(4);
        chk("R2 all expected starts seen", exp_cyc.size(), 0);
        summary();
    end
endmodule